// File: doc/BRIEF.md
# Wait-and-Latch Input Sanitiser

This block is a clocked interface cell between noisy comparator outputs and a controller that works in request/acknowledge style. The controller arms the cell with a one-cycle request pulse. The cell then watches its synchronised raw input for the condition chosen by the mode. When the condition appears, the cell latches it as a held output, and the output stays up until the controller returns a release pulse.

A single module covers every variant:
- level waits (for high and for low);
- edge waits (rising and falling);
- a two-step sequence that needs high and then low;
- a two-input mutual-exclusion arbiter;
- an arbiter whose output, once released, falls only after the granted input has gone low.

A cancel pulse withdraws a pending wait for good. The cell then stays deaf to its inputs until the controller arms it again.

Top module: `wait_latch_sanitiser`

## Requirements
- R1: While reset is asserted and after it is removed, `hit_o` is 2'b00 and the cell is idle, which means unarmed.
- R2: Raw inputs pass through SYNC_STAGES flops before detection. With the default of 2, a change on `raw_i` that fires a waiting cell first shows on `hit_o` at the third rising clock edge after the change. While the cell is idle, no raw activity changes `hit_o`.
- R3: Mode 3'd0 waits for `raw_i[0]` high and mode 3'd1 waits for `raw_i[0]` low. A level already present when the cell is armed fires it. Once fired, `hit_o` is held at 2'b01, whatever `raw_i` does, until release.
- R4: Mode 3'd2 fires only on a 0-to-1 change of synchronised `raw_i[0]`, and mode 3'd3 fires only on a 1-to-0 change. A level that is steady at arming does not fire. Once fired, `hit_o` is held at 2'b01.
- R5: In mode 3'd4, the cell first waits for `raw_i[0]` high and reports it as `hit_o`=2'b01. It then waits for `raw_i[0]` low and reports that as `hit_o`=2'b10, which is held until release.
- R6: In mode 3'd5, the first synchronised input seen high wins. Input `raw_i[0]` gives `hit_o`=2'b01 and input `raw_i[1]` gives 2'b10, and input 0 wins a tie. The grant is held until release, whatever either input does afterwards. At most one bit of `hit_o` is ever set.
- R7: Mode 3'd6 arbitrates in the same way as mode 3'd5. After release, the grant stays asserted until the synchronised granted input is low, and it drops on the next edge.
- R8: In all other modes, `hit_o` returns to 2'b00 on the clock edge that samples `rel_i`. The cell then ignores `raw_i` until a new `req_i`.
- R9: A `cancel_i` pulse while the cell is armed returns it to idle, and no later input level or edge fires it. A `cancel_i` pulse after the cell has fired has no effect on `hit_o`.
- R10: The mode is captured when `req_i` is sampled, so later changes of `mode_i` have no effect on the pending wait. Code 3'd7 behaves as mode 3'd0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Wait mode, captured on request |
| req_i | input | 1 | One-cycle pulse that arms the cell |
| rel_i | input | 1 | One-cycle pulse that releases a held output |
| cancel_i | input | 1 | One-cycle pulse that withdraws a pending wait |
| raw_i | input | 2 | Raw comparator inputs; only bit 0 is used outside the arbiter modes |
| hit_o | output | 2 | Held event output, at most one bit set |

## Verification
The bench builds the cell with SYNC_STAGES at its default of 2. With that depth the three-edge latency from a raw change to `hit_o` is exact, so the bench can sample one edge early and expect silence, then sample one edge later and expect the event. A vector table runs every mode against a level present at arming and against a later change of the raw input. This separates level triggers from edge triggers and covers the arbiter tie. Directed tests then cover cancellation before and after firing, a brief pulse on the losing arbiter input, capture of the mode at arming, and the reserved mode code.

// File: rtl/wait_latch_sanitiser.sv
module wait_latch_sanitiser #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       req_i,
  input  logic       rel_i,
  input  logic       cancel_i,
  input  logic [1:0] raw_i,
  output logic [1:0] hit_o
);

  localparam logic [2:0] M_HIGH  = 3'd0;
  localparam logic [2:0] M_LOW   = 3'd1;
  localparam logic [2:0] M_RISE  = 3'd2;
  localparam logic [2:0] M_FALL  = 3'd3;
  localparam logic [2:0] M_HILO  = 3'd4;
  localparam logic [2:0] M_ARB   = 3'd5;
  localparam logic [2:0] M_ARBLO = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_ARMED, S_HELD, S_HIGH_SEEN, S_DRAIN} state_t;

  state_t     state;
  logic [2:0] mode_q;
  logic       win;
  logic [1:0] sync_q [SYNC_STAGES];
  logic [1:0] cur, prev;
  logic [1:0] rise, fall;
  logic       fire;
  logic       arb_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      prev <= '0;
    end else begin
      sync_q[0] <= raw_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev <= cur;
    end
  end

  assign cur      = sync_q[SYNC_STAGES-1];
  assign rise     = cur & ~prev;
  assign fall     = ~cur & prev;
  assign arb_mode = (mode_q == M_ARB) || (mode_q == M_ARBLO);

  always_comb begin
    case (mode_q)
      M_LOW:          fire = ~cur[0];
      M_RISE:         fire = rise[0];
      M_FALL:         fire = fall[0];
      M_ARB, M_ARBLO: fire = |cur;
      default:        fire = cur[0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      mode_q <= M_HIGH;
      win    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_i) begin
          state  <= S_ARMED;
          mode_q <= (mode_i == 3'd7) ? M_HIGH : mode_i;
          win    <= 1'b0;
        end
        S_ARMED: if (cancel_i) begin
          state <= S_IDLE;
        end else if (fire) begin
          if (mode_q == M_HILO) begin
            state <= S_HIGH_SEEN;
          end else begin
            state <= S_HELD;
            win   <= arb_mode && !cur[0];
          end
        end
        S_HIGH_SEEN: if (rel_i) begin
          state <= S_IDLE;
        end else if (!cur[0]) begin
          state <= S_HELD;
          win   <= 1'b1;
        end
        S_HELD: if (rel_i) state <= (mode_q == M_ARBLO) ? S_DRAIN : S_IDLE;
        S_DRAIN: if (!cur[win]) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      S_HIGH_SEEN:     hit_o = 2'b01;
      S_HELD, S_DRAIN: hit_o = win ? 2'b10 : 2'b01;
      default:         hit_o = 2'b00;
    endcase
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !req_i) |=> hit_o == 2'b00);

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HELD && !rel_i) |=> $stable(hit_o));

  // R6
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_o));

  // R7
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DRAIN && cur[win]) |=> hit_o != 2'b00);

  // R8
  release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_HELD || state == S_HIGH_SEEN) && rel_i && mode_q != M_ARBLO)
      |=> hit_o == 2'b00);

  // R9
  cancel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ARMED && cancel_i) |=> hit_o == 2'b00);

endmodule

// File: tb/wait_latch_sanitiser_tb.sv
module wait_latch_sanitiser_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_i = '0;
  logic       req_i = 1'b0, rel_i = 1'b0, cancel_i = 1'b0;
  logic [1:0] raw_i = '0;
  logic [1:0] hit_o;
  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wait_latch_sanitiser dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .req_i(req_i), .rel_i(rel_i),
    .cancel_i(cancel_i), .raw_i(raw_i), .hit_o(hit_o));

  // {mode, raw before arming, raw after, expect armed, expect after change, expect after release}
  localparam logic [12:0] VEC [14] = '{
    {3'd0, 2'b00, 2'b01, 2'b00, 2'b01, 2'b00},
    {3'd0, 2'b01, 2'b00, 2'b01, 2'b01, 2'b00},
    {3'd1, 2'b01, 2'b00, 2'b00, 2'b01, 2'b00},
    {3'd1, 2'b00, 2'b01, 2'b01, 2'b01, 2'b00},
    {3'd2, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00},
    {3'd2, 2'b00, 2'b01, 2'b00, 2'b01, 2'b00},
    {3'd3, 2'b01, 2'b00, 2'b00, 2'b01, 2'b00},
    {3'd3, 2'b00, 2'b01, 2'b00, 2'b00, 2'b00},
    {3'd4, 2'b00, 2'b01, 2'b00, 2'b01, 2'b00},
    {3'd4, 2'b01, 2'b00, 2'b01, 2'b10, 2'b00},
    {3'd5, 2'b10, 2'b11, 2'b10, 2'b10, 2'b00},
    {3'd5, 2'b00, 2'b11, 2'b00, 2'b01, 2'b00},
    {3'd5, 2'b00, 2'b10, 2'b00, 2'b10, 2'b00},
    {3'd6, 2'b10, 2'b11, 2'b10, 2'b10, 2'b10}
  };

  function automatic string mode_tag(logic [2:0] m);
    case (m)
      3'd0, 3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd4:       return "R5";
      3'd5:       return "R6";
      default:    return "R7";
    endcase
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [1:0] exp);
    nchk++;
    if (hit_o !== exp) begin
      nerr++;
      $display("FAIL %s: hit_o=%b expected %b", tag, hit_o, exp);
    end
  endtask

  task automatic pulse_req();
    req_i = 1'b1; tick(1); req_i = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end

  initial begin
    tick(2);
    chk("R1 during reset", 2'b00);
    rst_n = 1'b1;
    tick(2);
    chk("R1 after reset", 2'b00);

    for (int v = 0; v < 14; v++) begin
      logic [2:0] m;
      m = VEC[v][12:10];
      mode_i = m; raw_i = VEC[v][9:8];
      tick(5);
      pulse_req();
      tick(4);
      chk(mode_tag(m), VEC[v][5:4]);
      raw_i = VEC[v][7:6];
      tick(5);
      chk(mode_tag(m), VEC[v][3:2]);
      rel_i = 1'b1; cancel_i = 1'b1; tick(1); rel_i = 1'b0; cancel_i = 1'b0;
      tick(3);
      chk((m == 3'd6) ? "R7" : "R8", VEC[v][1:0]);
      raw_i = 2'b00;
      tick(6);
      chk((m == 3'd6) ? "R7" : "R8", 2'b00);
    end

    // R2: exact latency, wait-high armed with input low
    mode_i = 3'd0; pulse_req(); tick(2);
    raw_i = 2'b01;
    tick(2); chk("R2 early", 2'b00);
    tick(1); chk("R2 third edge", 2'b01);
    // R8: drop on next edge, then ignore input still high
    rel_i = 1'b1; tick(1); rel_i = 1'b0;
    chk("R8 drop", 2'b00);
    tick(4); chk("R8 ignored", 2'b00);
    raw_i = 2'b00; tick(4);

    // R2: idle cell ignores inputs
    raw_i = 2'b11; tick(5); chk("R2 idle", 2'b00);
    raw_i = 2'b00; tick(4);

    // R9: cancel while armed is persistent
    mode_i = 3'd0; pulse_req(); tick(1);
    cancel_i = 1'b1; tick(1); cancel_i = 1'b0;
    raw_i = 2'b01; tick(6); chk("R9 cancelled", 2'b00);
    raw_i = 2'b00; tick(4);

    // R9: cancel after firing has no effect
    pulse_req(); raw_i = 2'b01; tick(5); chk("R9 fired", 2'b01);
    cancel_i = 1'b1; tick(1); cancel_i = 1'b0;
    tick(3); chk("R9 late cancel", 2'b01);
    rel_i = 1'b1; tick(1); rel_i = 1'b0; raw_i = 2'b00; tick(4);

    // R6: loser pulse after grant does not steal it
    mode_i = 3'd5; pulse_req(); raw_i = 2'b01; tick(5); chk("R6 grant", 2'b01);
    raw_i = 2'b10; tick(2); raw_i = 2'b00; tick(4); chk("R6 pulse ignored", 2'b01);
    rel_i = 1'b1; tick(1); rel_i = 1'b0; tick(4);

    // R10: mode captured at request
    mode_i = 3'd1; raw_i = 2'b01; tick(4);
    pulse_req(); mode_i = 3'd0;
    tick(5); chk("R10 captured", 2'b00);
    raw_i = 2'b00; tick(5); chk("R10 captured", 2'b01);
    rel_i = 1'b1; tick(1); rel_i = 1'b0; tick(4);

    // R10: reserved code acts as wait-high
    mode_i = 3'd7; raw_i = 2'b01; tick(4);
    pulse_req(); tick(4); chk("R10 code 7", 2'b01);
    rel_i = 1'b1; tick(1); rel_i = 1'b0; raw_i = 2'b00; tick(4);

    finish_up();
  end
endmodule